// File: doc/BRIEF.md
# Posted Write Buffer with Combining

This block sits between a processor-side write port and a burst-capable bus master port. Every incoming write is one 32-bit word carrying a word address and four byte enables. The buffer accepts it in the same cycle it is offered and holds it in an entry that keeps address, data and byte enables together. The writer keeps going while the downstream side is still waiting for the bus, and is held back only when every entry is occupied.

When the downstream bus grants the buffer, the oldest entries drain in arrival order. With combining enabled, the buffer looks at the entries present at the moment of the grant. It counts how many of them, starting from the oldest, each sit exactly one word above the entry before. That run goes out as one burst with one beat per cycle. An entry that breaks the run, either through a gap or a lower address, starts a new transaction with a new request. With combining disabled, every entry drains as its own single-beat transaction.

The control is a three-state machine:
- ST_IDLE: nothing outstanding.
- ST_REQ: the bus request is raised.
- ST_BURST: beats are issued.

It has three transitions:
- IDLE→REQ (buffer not empty).
- REQ→BURST (grant sampled; burst length fixed here).
- BURST→IDLE (final beat issued).

Top module: `wpost_buffer`

## Requirements
- R1: After reset, `up_ready` is 1, `dn_req` is 0 and `dn_valid` is 0.
- R2: A write offered with `up_valid` while `up_ready` is 1 is stored at that clock edge, whether or not the downstream bus is granted. `up_ready` stays 1 while fewer than DEPTH entries are held.
- R3: With DEPTH entries held, `up_ready` is 0. A write offered then is dropped and never appears downstream.
- R4: `up_ready` returns to 1 in the cycle after the beat that frees an entry.
- R5: With `cfg_merge_en` = 1, a run of entries starting at the oldest, each with word address one greater than its predecessor (byte address +4), is issued as one burst. The burst has one beat per consecutive cycle, `dn_last` = 0 on every beat but the final one, and `dn_last` = 1 on the final one.
- R6: An entry whose word address is not exactly one above the previous entry's ends the burst before it. This covers a gap and a lower address. That entry begins a new transaction with its own request.
- R7: With `cfg_merge_en` = 0, every entry is issued as a single beat with `dn_last` = 1.
- R8: Beats appear in arrival order. `dn_addr` equals the word address times four (bits [1:0] are 0). `dn_data` and `dn_be` equal the stored write unchanged.
- R9: Burst length is fixed when the grant is sampled. An entry stored after that edge is not appended, even if adjacent.
- R10: `dn_req` stays 1 until `dn_gnt` is sampled high. The first beat appears in the cycle after that edge, and `dn_req` is 0 during beats. At least one cycle with `dn_valid` = 0 follows every final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_merge_en | input | 1 | 1 = combine adjacent entries into bursts |
| up_valid | input | 1 | Write offered |
| up_ready | output | 1 | Buffer can accept a write |
| up_waddr | input | ADDR_W-2 (30) | Word address of the write (byte address bits [31:2]) |
| up_data | input | DATA_W (32) | Write data |
| up_be | input | DATA_W/8 (4) | Byte enables |
| dn_req | output | 1 | Bus request |
| dn_gnt | input | 1 | Bus grant |
| dn_valid | output | 1 | Beat present this cycle |
| dn_last | output | 1 | Final beat of the transaction |
| dn_addr | output | ADDR_W (32) | Byte address of the beat |
| dn_data | output | DATA_W (32) | Beat data |
| dn_be | output | DATA_W/8 (4) | Beat byte enables |

## Verification
The in-RTL assertions check on every cycle that:
- The storage never overflows or underflows.
- `up_ready` returns after every freed entry.
- A held request persists until granted.
- Beats inside a burst are back to back and step the address by four.
- A final beat is followed by an idle cycle.
- With combining off, every transaction is a single beat.

Only the directed scenarios can show whole-transaction properties:
- A full run really merges into one burst.
- Gaps and descending addresses split transactions at the right entry.
- Data and byte enables arrive intact and in order.
- A write dropped while full never emerges.
- A write arriving mid-burst becomes a transaction of its own.

// File: rtl/wpost_pkg.sv
package wpost_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_BURST = 2'd2
    } wp_state_e;

endpackage

// File: rtl/wpost_store.sv
module wpost_store #(
    parameter int DEPTH  = 8,
    parameter int DA_W   = 30,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [DA_W-1:0]                push_addr,
    input  logic [DATA_W-1:0]              push_data,
    input  logic [BE_W-1:0]                push_be,
    input  logic                           pop,
    output logic                           full,
    output logic                           empty,
    output logic [CNT_W-1:0]               count,
    output logic [DEPTH-1:0][DA_W-1:0]     ord_addr,
    output logic [DATA_W-1:0]              head_data,
    output logic [BE_W-1:0]                head_be
);

    logic [DA_W-1:0]   mem_addr [DEPTH];
    logic [DATA_W-1:0] mem_data [DEPTH];
    logic [BE_W-1:0]   mem_be   [DEPTH];
    logic [PTR_W-1:0]  head_q;
    logic [PTR_W-1:0]  tail_q;
    logic [CNT_W-1:0]  count_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) begin
                tail_q <= bump(tail_q);
            end
            if (pop) begin
                head_q <= bump(head_q);
            end
            unique case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // entry payload: no reset needed, occupancy governs validity
    always_ff @(posedge clk) begin
        if (push) begin
            mem_addr[tail_q] <= push_addr;
            mem_data[tail_q] <= push_data;
            mem_be[tail_q]   <= push_be;
        end
    end

    assign count     = count_q;
    assign full      = (count_q == CNT_W'(DEPTH));
    assign empty     = (count_q == '0);
    assign head_data = mem_data[head_q];
    assign head_be   = mem_be[head_q];

    // addresses presented oldest first
    for (genvar g = 0; g < DEPTH; g++) begin : g_ord
        logic [PTR_W:0] sum;
        logic [PTR_W:0] idx;
        assign sum = {1'b0, head_q} + (PTR_W + 1)'(g);
        assign idx = (sum >= (PTR_W + 1)'(DEPTH)) ? sum - (PTR_W + 1)'(DEPTH) : sum;
        assign ord_addr[g] = mem_addr[idx[PTR_W-1:0]];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R8

endmodule

// File: rtl/wpost_runlen.sv
module wpost_runlen #(
    parameter int DEPTH = 8,
    parameter int DA_W  = 30,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][DA_W-1:0] ord_addr,
    input  logic [CNT_W-1:0]           count,
    input  logic                       merge_en,
    output logic [CNT_W-1:0]           run_len
);

    // adj[g]: entry g (in age order) sits one word above entry g-1
    logic [DEPTH-1:1] adj;

    for (genvar g = 1; g < DEPTH; g++) begin : g_adj
        assign adj[g] = ({1'b0, ord_addr[g]} == ({1'b0, ord_addr[g-1]} + (DA_W + 1)'(1)));
    end

    // leading run of adjacent, occupied entries
    always_comb begin
        logic open;
        open    = merge_en;
        run_len = CNT_W'(1);
        for (int i = 1; i < DEPTH; i++) begin
            if (open && adj[i] && (CNT_W'(i) < count)) begin
                run_len = CNT_W'(i + 1);
            end else begin
                open = 1'b0;
            end
        end
    end

endmodule

// File: rtl/wpost_ctrl.sv
module wpost_ctrl
    import wpost_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             empty,
    input  logic             dn_gnt,
    input  logic [CNT_W-1:0] run_len,
    output logic             dn_req,
    output logic             dn_valid,
    output logic             dn_last,
    output logic             pop
);

    wp_state_e        state_q;
    wp_state_e        state_d;
    logic [CNT_W-1:0] beats_q;

    // state register and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beats_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_REQ && dn_gnt) begin
                beats_q <= run_len;
            end else if (state_q == ST_BURST) begin
                beats_q <= beats_q - 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!empty)                  state_d = ST_REQ;
            ST_REQ:   if (dn_gnt)                  state_d = ST_BURST;
            ST_BURST: if (beats_q == CNT_W'(1))    state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dn_req   = 1'b0;
        dn_valid = 1'b0;
        dn_last  = 1'b0;
        pop      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_REQ:   dn_req = 1'b1;
            ST_BURST: begin
                dn_valid = 1'b1;
                pop      = 1'b1;
                dn_last  = (beats_q == CNT_W'(1));
            end
            default:  ;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_gnt |=> dn_req); // R10

    AST_LAST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_last |=> !dn_valid); // R10

    AST_BEATS_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_last |=> dn_valid); // R5

endmodule

// File: rtl/wpost_buffer.sv
module wpost_buffer #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8,
    parameter int DA_W   = ADDR_W - 2,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_merge_en,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ADDR_W-1:2] up_waddr,
    input  logic [DATA_W-1:0] up_data,
    input  logic [BE_W-1:0]   up_be,
    output logic              dn_req,
    input  logic              dn_gnt,
    output logic              dn_valid,
    output logic              dn_last,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_data,
    output logic [BE_W-1:0]   dn_be
);

    logic                       push;
    logic                       pop;
    logic                       full;
    logic                       empty;
    logic [CNT_W-1:0]           count;
    logic [DEPTH-1:0][DA_W-1:0] ord_addr;
    logic [CNT_W-1:0]           run_len;

    assign up_ready = !full;
    assign push     = up_valid && up_ready;

    wpost_store #(
        .DEPTH  (DEPTH),
        .DA_W   (DA_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W),
        .CNT_W  (CNT_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (up_waddr),
        .push_data (up_data),
        .push_be   (up_be),
        .pop       (pop),
        .full      (full),
        .empty     (empty),
        .count     (count),
        .ord_addr  (ord_addr),
        .head_data (dn_data),
        .head_be   (dn_be)
    );

    wpost_runlen #(
        .DEPTH (DEPTH),
        .DA_W  (DA_W),
        .CNT_W (CNT_W)
    ) i_runlen (
        .ord_addr (ord_addr),
        .count    (count),
        .merge_en (cfg_merge_en),
        .run_len  (run_len)
    );

    wpost_ctrl #(
        .CNT_W (CNT_W)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .empty    (empty),
        .dn_gnt   (dn_gnt),
        .run_len  (run_len),
        .dn_req   (dn_req),
        .dn_valid (dn_valid),
        .dn_last  (dn_last),
        .pop      (pop)
    );

    assign dn_addr = {ord_addr[0], 2'b00};

    AST_ADJ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_last |=> dn_addr == $past(dn_addr) + ADDR_W'(4)); // R5

    AST_OFF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_valid) && !$past(cfg_merge_en) |-> dn_last); // R7

    AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> up_ready); // R4

    AST_NO_REQ_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !dn_req); // R10

endmodule

// File: tb/test_wpost_buffer.sv
module test_wpost_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_merge_en = 1'b1;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic [31:2] up_waddr = '0;
    logic [31:0] up_data = '0;
    logic [3:0]  up_be = '0;
    logic        dn_req;
    logic        dn_gnt = 1'b0;
    logic        dn_valid;
    logic        dn_last;
    logic [31:0] dn_addr;
    logic [31:0] dn_data;
    logic [3:0]  dn_be;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_addr [64];
    logic [31:0] exp_data [64];
    logic [3:0]  exp_be   [64];
    logic        exp_last [64];
    int          exp_n = 0;

    logic [31:0] got_addr [64];
    logic [31:0] got_data [64];
    logic [3:0]  got_be   [64];
    logic        got_last [64];
    int          got_n = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wpost_buffer #(.DEPTH(DEPTH)) i_wpost_buffer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_merge_en (cfg_merge_en),
        .up_valid     (up_valid),
        .up_ready     (up_ready),
        .up_waddr     (up_waddr),
        .up_data      (up_data),
        .up_be        (up_be),
        .dn_req       (dn_req),
        .dn_gnt       (dn_gnt),
        .dn_valid     (dn_valid),
        .dn_last      (dn_last),
        .dn_addr      (dn_addr),
        .dn_data      (dn_data),
        .dn_be        (dn_be)
    );

    // beat monitor
    always @(negedge clk) begin
        if (rst_n && dn_valid && got_n < 64) begin
            got_addr[got_n] = dn_addr;
            got_data[got_n] = dn_data;
            got_be[got_n]   = dn_be;
            got_last[got_n] = dn_last;
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_beats();
        got_n = 0;
        exp_n = 0;
    endtask

    task automatic want(input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] b, input logic l);
        exp_addr[exp_n] = a;
        exp_data[exp_n] = d;
        exp_be[exp_n]   = b;
        exp_last[exp_n] = l;
        exp_n++;
    endtask

    task automatic put(input logic [31:0] ba, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        up_valid = 1'b1;
        up_waddr = ba[31:2];
        up_data  = d;
        up_be    = b;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic wait_beats(input int n);
        int guard;
        guard = 0;
        while (got_n < n && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        dn_gnt = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic drain(input int n);
        @(negedge clk);
        dn_gnt = 1'b1;
        wait_beats(n);
    endtask

    task automatic compare(input string req);
        chk(got_n == exp_n, req, "beat count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_addr[i] == exp_addr[i], req, "beat addr", got_addr[i], exp_addr[i]);
            chk(got_data[i] == exp_data[i], "R8", "beat data", got_data[i], exp_data[i]);
            chk(got_be[i] == exp_be[i], "R8", "beat be", {28'd0, got_be[i]}, {28'd0, exp_be[i]});
            chk(got_last[i] == exp_last[i], req, "beat last", {31'd0, got_last[i]}, {31'd0, exp_last[i]});
        end
    endtask

    task automatic t_reset();
        chk(up_ready == 1'b1, "R1", "up_ready after reset", {31'd0, up_ready}, 32'd1);
        chk(dn_req == 1'b0, "R1", "dn_req after reset", {31'd0, dn_req}, 32'd0);
        chk(dn_valid == 1'b0, "R1", "dn_valid after reset", {31'd0, dn_valid}, 32'd0);
    endtask

    // R5 R2 R8 R10: four adjacent words merge into one burst
    task automatic t_merge_run();
        clear_beats();
        cfg_merge_en = 1'b1;
        put(32'h0000_1000, 32'hA000_0001, 4'hF);
        put(32'h0000_1004, 32'hA000_0002, 4'h3);
        put(32'h0000_1008, 32'hA000_0003, 4'hC);
        chk(up_ready == 1'b1, "R2", "ready while ungranted", {31'd0, up_ready}, 32'd1);
        put(32'h0000_100C, 32'hA000_0004, 4'h1);
        chk(dn_req == 1'b1, "R10", "request raised", {31'd0, dn_req}, 32'd1);
        chk(dn_valid == 1'b0, "R10", "no beat before grant", {31'd0, dn_valid}, 32'd0);
        want(32'h0000_1000, 32'hA000_0001, 4'hF, 1'b0);
        want(32'h0000_1004, 32'hA000_0002, 4'h3, 1'b0);
        want(32'h0000_1008, 32'hA000_0003, 4'hC, 1'b0);
        want(32'h0000_100C, 32'hA000_0004, 4'h1, 1'b1);
        @(negedge clk);
        dn_gnt = 1'b1;
        @(negedge clk);
        chk(dn_valid == 1'b1, "R10", "first beat after grant", {31'd0, dn_valid}, 32'd1);
        chk(dn_req == 1'b0, "R10", "request low in burst", {31'd0, dn_req}, 32'd0);
        wait_beats(4);
        compare("R5");
    endtask

    // R7: combining off gives single beats
    task automatic t_merge_off();
        clear_beats();
        cfg_merge_en = 1'b0;
        put(32'h0000_2000, 32'hB000_0001, 4'hF);
        put(32'h0000_2004, 32'hB000_0002, 4'h6);
        put(32'h0000_2008, 32'hB000_0003, 4'h9);
        want(32'h0000_2000, 32'hB000_0001, 4'hF, 1'b1);
        want(32'h0000_2004, 32'hB000_0002, 4'h6, 1'b1);
        want(32'h0000_2008, 32'hB000_0003, 4'h9, 1'b1);
        drain(3);
        compare("R7");
        cfg_merge_en = 1'b1;
    endtask

    // R6: gap and descending address split transactions
    task automatic t_gaps();
        clear_beats();
        cfg_merge_en = 1'b1;
        put(32'h0000_0100, 32'hC000_0001, 4'hF);
        put(32'h0000_0104, 32'hC000_0002, 4'hF);
        put(32'h0000_010C, 32'hC000_0003, 4'h2);
        put(32'h0000_0110, 32'hC000_0004, 4'h4);
        put(32'h0000_010C, 32'hC000_0005, 4'h8);
        want(32'h0000_0100, 32'hC000_0001, 4'hF, 1'b0);
        want(32'h0000_0104, 32'hC000_0002, 4'hF, 1'b1);
        want(32'h0000_010C, 32'hC000_0003, 4'h2, 1'b0);
        want(32'h0000_0110, 32'hC000_0004, 4'h4, 1'b1);
        want(32'h0000_010C, 32'hC000_0005, 4'h8, 1'b1);
        drain(5);
        compare("R6");
    endtask

    // R3 R4: full buffer refuses a write, ready returns after first pop
    task automatic t_full();
        clear_beats();
        cfg_merge_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            put(32'h0000_3000 + 32'(i * 4), 32'hD000_0000 + 32'(i), 4'(i + 1));
            want(32'h0000_3000 + 32'(i * 4), 32'hD000_0000 + 32'(i), 4'(i + 1), (i == DEPTH - 1));
        end
        chk(up_ready == 1'b0, "R3", "ready low when full", {31'd0, up_ready}, 32'd0);
        put(32'h0000_9000, 32'hDEAD_BEEF, 4'hF);
        @(negedge clk);
        dn_gnt = 1'b1;
        @(negedge clk);
        chk(up_ready == 1'b0, "R4", "ready during first beat", {31'd0, up_ready}, 32'd0);
        @(negedge clk);
        chk(up_ready == 1'b1, "R4", "ready after first beat", {31'd0, up_ready}, 32'd1);
        wait_beats(DEPTH);
        compare("R3");
    endtask

    // R9: adjacent write arriving mid-burst is not appended
    task automatic t_late();
        clear_beats();
        cfg_merge_en = 1'b1;
        put(32'h0000_4000, 32'hE000_0001, 4'hF);
        put(32'h0000_4004, 32'hE000_0002, 4'h5);
        want(32'h0000_4000, 32'hE000_0001, 4'hF, 1'b0);
        want(32'h0000_4004, 32'hE000_0002, 4'h5, 1'b1);
        want(32'h0000_4008, 32'hE000_0003, 4'hA, 1'b1);
        @(negedge clk);
        dn_gnt = 1'b1;
        @(negedge clk);
        chk(dn_valid == 1'b1, "R9", "burst started", {31'd0, dn_valid}, 32'd1);
        up_valid = 1'b1;
        up_waddr = 30'h0000_1002;
        up_data  = 32'hE000_0003;
        up_be    = 4'hA;
        @(negedge clk);
        up_valid = 1'b0;
        wait_beats(3);
        compare("R9");
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=%0d expected=0", 1);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge_run();
        t_merge_off();
        t_gaps();
        t_full();
        t_late();
        summary();
        $finish;
    end

endmodule